// File: doc/BRIEF.md
# Programmable Carry Lookup Execution Unit

This block is a 32-bit execution unit that evaluates a small dataflow subgraph in one pass. The subgraph is a set of bitwise logic operations placed around at most one addition or subtraction. It takes four operand words. At every bit position, two 16-entry truth tables turn the four operand bits into a generate flag and a propagate flag. One parallel-prefix network turns those flags into a carry for every bit. Two 32-entry output tables then combine the four operand bits and the carry arriving at that bit into one bit of each of two result words.

The configuration is written as one word through a write-enable port and held in registers until the next write. Operands are sampled on each rising clock edge. Both results appear registered one cycle later. A configuration bit selects the carry injected into bit 0, so a subtraction is formed by inverting one operand inside the tables and injecting a 1. When no arithmetic is wanted, the generate table is left at zero and the output tables alone implement any four-input bitwise function.

Top module: `pcl_accel`

## Requirements
- R1: While `rst` is high, on the next edge both results and all configuration fields become zero. Until a configuration is written, both results stay zero for any operands.
- R2: With the generate table set to in1&in2, the propagate table set to in1^in2, the output table set to in1^in2^carry and the carry select at 0, `res0` equals `op_a + op_b` modulo 2^32.
- R3: With the generate table set to in1&~in2, the propagate table set to ~(in1^in2), the output table set to ~(in1^in2)^carry and the carry select at 1, `res0` equals `op_a - op_b` modulo 2^32.
- R4: With the generate table all zero and the carry select at 0, each result bit is the output-table entry addressed by the four operand bits of that position. For example, (a^b)|(c&d) is computed in one table.
- R5: The carry select bit sets the carry into bit 0. With the addition tables of R2 and the select at 1, `res0` equals `op_a + op_b + 1`.
- R6: A table index is {carry, in4, in3, in2, in1}, with in1 (`op_a`) at bit 0, in2 (`op_b`) at bit 1, in3 (`op_c`) at bit 2, in4 (`op_d`) at bit 3 and the incoming carry at bit 4. The 16-entry tables use the low four of these index bits.
- R7: A carry travels across the full width. With the addition tables, `op_a`=0xFFFFFFFF and `op_b`=1, `res0` is 0. An output table that returns only the carry index bit yields 0xFFFFFFFE, which is the carry into every bit.
- R8: Configuration inputs have no effect while `cfg_we` is low. The stored configuration and the results it produces are unchanged.
- R9: Results reflect the operands and the stored configuration sampled at the previous rising edge. A configuration written at an edge first applies to operands sampled at the following edge.
- R10: For any table contents and carry select, both results match a bit-serial model. That model evaluates the same tables bit by bit from bit 0 upward and passes carry = g | p&carry to the next bit.
- R11: `res0` and `res1` are formed from independent output tables that share the same operands and carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Writes all configuration fields this edge |
| cfg_gen | input | 16 | Generate truth table |
| cfg_prop | input | 16 | Propagate truth table |
| cfg_out0 | input | 32 | Output table for res0 |
| cfg_out1 | input | 32 | Output table for res1 |
| cfg_cin | input | 1 | Carry injected into bit 0 |
| op_a | input | 32 | Operand in1 |
| op_b | input | 32 | Operand in2 |
| op_c | input | 32 | Operand in3 |
| op_d | input | 32 | Operand in4 |
| res0 | output | 32 | Registered first result |
| res1 | output | 32 | Registered second result |

## Verification
The bench builds the unit with its default width of 32. That width gives five prefix levels, and the top level spans 16 positions. A carry from bit 0 therefore has to pass through every level before it reaches bit 31. The full-width carry case and the random table cases exercise each level and each span. The random cases are compared against a ripple model that shares nothing with the prefix structure.

// File: rtl/pcl_pkg.sv
package pcl_pkg;
    localparam int NUM_OPS     = 4;
    localparam int GP_ENTRIES  = 1 << NUM_OPS;
    localparam int OUT_ENTRIES = 1 << (NUM_OPS + 1);

    typedef logic [GP_ENTRIES-1:0]  gp_tab_t;
    typedef logic [OUT_ENTRIES-1:0] out_tab_t;

    typedef struct packed {
        out_tab_t out1;
        out_tab_t out0;
        gp_tab_t  prop;
        gp_tab_t  gen;
        logic     cin0;
    } pcl_cfg_t;

    function automatic logic look_gp(input gp_tab_t tab, input logic [NUM_OPS-1:0] idx);
        return tab[idx];
    endfunction

    function automatic logic look_out(input out_tab_t tab, input logic [NUM_OPS:0] idx);
        return tab[idx];
    endfunction
endpackage

// File: rtl/pcl_gp_stage.sv
module pcl_gp_stage
    import pcl_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [WIDTH-1:0] op_c,
    input  logic [WIDTH-1:0] op_d,
    input  gp_tab_t          gen_tab,
    input  gp_tab_t          prop_tab,
    output logic [WIDTH-1:0] gen,
    output logic [WIDTH-1:0] prop
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [NUM_OPS-1:0] idx;
        assign idx     = {op_d[i], op_c[i], op_b[i], op_a[i]};
        assign gen[i]  = look_gp(gen_tab, idx);
        assign prop[i] = look_gp(prop_tab, idx);
    end
endmodule

// File: rtl/pcl_prefix.sv
module pcl_prefix #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] g_in,
    input  logic [WIDTH-1:0] p_in,
    input  logic             cin0,
    output logic [WIDTH-1:0] carry_in
);
    localparam int LEVELS = $clog2(WIDTH);

    logic [WIDTH-1:0] g_lv [LEVELS+1];
    logic [WIDTH-1:0] p_lv [LEVELS+1];
    logic [WIDTH-1:0] c_out;

    assign g_lv[0] = g_in;
    assign p_lv[0] = p_in;

    for (genvar lv = 0; lv < LEVELS; lv++) begin : g_level
        localparam int SPAN = 1 << lv;
        always_comb begin
            for (int i = 0; i < WIDTH; i++) begin
                if (i >= SPAN) begin
                    g_lv[lv+1][i] = g_lv[lv][i] | (p_lv[lv][i] & g_lv[lv][i-SPAN]);
                    p_lv[lv+1][i] = p_lv[lv][i] & p_lv[lv][i-SPAN];
                end else begin
                    g_lv[lv+1][i] = g_lv[lv][i];
                    p_lv[lv+1][i] = p_lv[lv][i];
                end
            end
        end
    end

    assign c_out    = g_lv[LEVELS] | (p_lv[LEVELS] & {WIDTH{cin0}});
    assign carry_in = {c_out[WIDTH-2:0], cin0};
endmodule

// File: rtl/pcl_out_stage.sv
module pcl_out_stage
    import pcl_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [WIDTH-1:0] op_c,
    input  logic [WIDTH-1:0] op_d,
    input  logic [WIDTH-1:0] carry_in,
    input  out_tab_t         tab0,
    input  out_tab_t         tab1,
    output logic [WIDTH-1:0] out0,
    output logic [WIDTH-1:0] out1
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        logic [NUM_OPS:0] idx;
        assign idx     = {carry_in[i], op_d[i], op_c[i], op_b[i], op_a[i]};
        assign out0[i] = look_out(tab0, idx);
        assign out1[i] = look_out(tab1, idx);
    end
endmodule

// File: rtl/pcl_accel.sv
module pcl_accel
    import pcl_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [15:0]      cfg_gen,
    input  logic [15:0]      cfg_prop,
    input  logic [31:0]      cfg_out0,
    input  logic [31:0]      cfg_out1,
    input  logic             cfg_cin,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    input  logic [WIDTH-1:0] op_c,
    input  logic [WIDTH-1:0] op_d,
    output logic [WIDTH-1:0] res0,
    output logic [WIDTH-1:0] res1
);
    pcl_cfg_t         cfg_wr_w;
    pcl_cfg_t         cfg_q;
    logic [WIDTH-1:0] g_w, p_w, carry_in_w, out0_w, out1_w;

    assign cfg_wr_w.out1 = cfg_out1;
    assign cfg_wr_w.out0 = cfg_out0;
    assign cfg_wr_w.prop = cfg_prop;
    assign cfg_wr_w.gen  = cfg_gen;
    assign cfg_wr_w.cin0 = cfg_cin;

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (cfg_we) cfg_q <= cfg_wr_w;
    end

    pcl_gp_stage #(.WIDTH(WIDTH)) u_gp (
        .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d),
        .gen_tab(cfg_q.gen), .prop_tab(cfg_q.prop),
        .gen(g_w), .prop(p_w)
    );

    pcl_prefix #(.WIDTH(WIDTH)) u_pfx (
        .g_in(g_w), .p_in(p_w), .cin0(cfg_q.cin0), .carry_in(carry_in_w)
    );

    pcl_out_stage #(.WIDTH(WIDTH)) u_out (
        .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d),
        .carry_in(carry_in_w), .tab0(cfg_q.out0), .tab1(cfg_q.out1),
        .out0(out0_w), .out1(out1_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res0 <= '0;
            res1 <= '0;
        end else begin
            res0 <= out0_w;
            res1 <= out1_w;
        end
    end
endmodule

// File: rtl/pcl_accel_chk.sv
module pcl_accel_chk
    import pcl_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_we,
    input pcl_cfg_t         cfg_wr,
    input pcl_cfg_t         cfg_q,
    input logic [WIDTH-1:0] carry_in,
    input logic [WIDTH-1:0] res0,
    input logic [WIDTH-1:0] res1
);
    // R1: reset clears both results on the following edge
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (res0 == '0 && res1 == '0));

    // R8: stored configuration does not move without a write
    assert_cfg_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !cfg_we |=> $stable(cfg_q));

    // R9: a write takes the presented fields on that edge
    assert_cfg_load_R9: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> (cfg_q == $past(cfg_wr)));

    // R4: no generate and no injected carry means no carry anywhere
    assert_no_carry_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.gen == '0 && !cfg_q.cin0) |-> (carry_in == '0));

    // R7: generate everywhere means a carry into every bit above bit 0
    assert_full_carry_R7: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.gen == '1) |-> (carry_in[WIDTH-1:1] == '1));

    // R5: bit 0 carry follows the stored select
    assert_cin_sel_R5: assert property (@(posedge clk) disable iff (rst)
        cfg_q.cin0 |-> carry_in[0]);
endmodule

bind pcl_accel pcl_accel_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wr(cfg_wr_w), .cfg_q(cfg_q),
    .carry_in(carry_in_w), .res0(res0), .res1(res1)
);

// File: tb/pcl_accel_test.sv
module pcl_accel_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_gen = '0, cfg_prop = '0;
    logic [31:0] cfg_out0 = '0, cfg_out1 = '0;
    logic        cfg_cin = 1'b0;
    logic [31:0] op_a = '0, op_b = '0, op_c = '0, op_d = '0;
    logic [31:0] res0, res1;

    int total = 0;
    int bad = 0;
    bit done = 0;

    // bench copy of the configuration last written
    logic [15:0] m_gen = '0, m_prop = '0;
    logic [31:0] m_out0 = '0, m_out1 = '0;
    logic        m_cin = 1'b0;

    always #2 clk = ~clk;

    pcl_accel uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_gen(cfg_gen), .cfg_prop(cfg_prop),
        .cfg_out0(cfg_out0), .cfg_out1(cfg_out1), .cfg_cin(cfg_cin),
        .op_a(op_a), .op_b(op_b), .op_c(op_c), .op_d(op_d), .res0(res0), .res1(res1)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // kinds: 0 a^b^c_in, 1 a&b, 2 a^b, 3 ~(a^b)^c_in, 4 a&~b, 5 ~(a^b),
    // 6 (a^b)|(c&d), 7 c_in, 8 in3, 9 in4, 10 zero
    function automatic logic [31:0] tab(input int kind);
        logic [31:0] t;
        for (int i = 0; i < 32; i++) begin
            logic a, b, c, d, k;
            a = i[0]; b = i[1]; c = i[2]; d = i[3]; k = i[4];
            case (kind)
                0: t[i] = a ^ b ^ k;
                1: t[i] = a & b;
                2: t[i] = a ^ b;
                3: t[i] = ~(a ^ b) ^ k;
                4: t[i] = a & ~b;
                5: t[i] = ~(a ^ b);
                6: t[i] = (a ^ b) | (c & d);
                7: t[i] = k;
                8: t[i] = c;
                9: t[i] = d;
                default: t[i] = 1'b0;
            endcase
        end
        return t;
    endfunction

    task automatic present(input logic [15:0] g, input logic [15:0] p, input logic [31:0] o0,
                           input logic [31:0] o1, input logic ci, input logic we);
        cfg_gen = g; cfg_prop = p; cfg_out0 = o0; cfg_out1 = o1; cfg_cin = ci; cfg_we = we;
    endtask

    task automatic load(input logic [15:0] g, input logic [15:0] p, input logic [31:0] o0,
                        input logic [31:0] o1, input logic ci);
        @(negedge clk);
        present(g, p, o0, o1, ci, 1'b1);
        m_gen = g; m_prop = p; m_out0 = o0; m_out1 = o1; m_cin = ci;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic exec(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c, input logic [31:0] d);
        @(negedge clk);
        op_a = a; op_b = b; op_c = c; op_d = d;
        @(posedge clk);
        #1;
    endtask

    task automatic ripple(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                          input logic [31:0] d, output logic [31:0] r0, output logic [31:0] r1);
        logic k;
        k = m_cin;
        for (int i = 0; i < 32; i++) begin
            logic [3:0] ix;
            ix = {d[i], c[i], b[i], a[i]};
            r0[i] = m_out0[{k, ix}];
            r1[i] = m_out1[{k, ix}];
            k = m_gen[ix] | (m_prop[ix] & k);
        end
    endtask

    task automatic t_reset;
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R1 res0 in reset", res0, 32'h0);
        check("R1 res1 in reset", res1, 32'h0);
        @(negedge clk);
        rst = 1'b0;
        exec(32'h1234_5678, 32'hFFFF_0000, 32'hA5A5_A5A5, 32'h0F0F_0F0F);
        check("R1 res0 unconfigured", res0, 32'h0);
        check("R1 res1 unconfigured", res1, 32'h0);
    endtask

    task automatic t_add;
        load(tab(1)[15:0], tab(2)[15:0], tab(0), tab(7), 1'b0);
        exec(32'd100, 32'd23, 32'h0, 32'h0);
        check("R2 small add", res0, 32'd123);
        exec(32'h8000_0001, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 32'h1234_0000);
        check("R2 add wrap", res0, 32'h0);
        exec(32'hFFFF_FFFF, 32'h1, 32'h0, 32'h0);
        check("R7 full carry sum", res0, 32'h0);
        check("R7 carry vector", res1, 32'hFFFF_FFFE);
    endtask

    task automatic t_add_cin;
        load(tab(1)[15:0], tab(2)[15:0], tab(0), tab(10), 1'b1);
        exec(32'd41, 32'd58, 32'h0, 32'h0);
        check("R5 add plus one", res0, 32'd100);
        exec(32'hFFFF_FFFF, 32'h0, 32'h0, 32'h0);
        check("R5 injected carry wraps", res0, 32'h0);
    endtask

    task automatic t_sub;
        load(tab(4)[15:0], tab(5)[15:0], tab(3), tab(2), 1'b1);
        exec(32'd1000, 32'd1, 32'h0, 32'h0);
        check("R3 sub", res0, 32'd999);
        exec(32'd5, 32'd9, 32'h0, 32'h0);
        check("R3 sub negative", res0, 32'hFFFF_FFFC);
        check("R11 second output xor", res1, 32'd5 ^ 32'd9);
    endtask

    task automatic t_logic;
        logic [31:0] a, b, c, d;
        a = 32'hF0F0_1234; b = 32'h0FF0_4321; c = 32'hCCCC_AAAA; d = 32'hAAAA_FFFF;
        load(16'h0, 16'h0, tab(6), tab(1), 1'b0);
        exec(a, b, c, d);
        check("R4 collapsed logic", res0, (a ^ b) | (c & d));
        check("R11 independent and", res1, a & b);
    endtask

    task automatic t_index;
        load(16'h0, 16'h0, tab(8), tab(9), 1'b0);
        exec(32'h1111_1111, 32'h2222_2222, 32'h3C3C_5A5A, 32'h9696_0FF0);
        check("R6 in3 at index bit 2", res0, 32'h3C3C_5A5A);
        check("R6 in4 at index bit 3", res1, 32'h9696_0FF0);
        load(16'h0, 16'h0, tab(8), tab(7), 1'b1);
        exec(32'h0, 32'h0, 32'h0, 32'h0);
        check("R6 carry at index bit 4", res1, 32'h0000_0001);
    endtask

    task automatic t_ignore;
        load(tab(1)[15:0], tab(2)[15:0], tab(0), tab(10), 1'b0);
        @(negedge clk);
        present(16'hFFFF, 16'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, 1'b0);
        exec(32'd7, 32'd8, 32'h0, 32'h0);
        check("R8 fields ignored res0", res0, 32'd15);
        check("R8 fields ignored res1", res1, 32'h0);
    endtask

    task automatic t_timing;
        exec(32'd3, 32'd4, 32'h0, 32'h0);
        @(negedge clk);
        op_a = 32'd50; op_b = 32'd60;
        #1;
        check("R9 result held before edge", res0, 32'd7);
        @(posedge clk);
        #1;
        check("R9 result after edge", res0, 32'd110);
        // write a new config on the same edge as new operands
        @(negedge clk);
        present(16'h0, 16'h0, tab(2), tab(10), 1'b0, 1'b1);
        op_a = 32'h0000_00F0; op_b = 32'h0000_000F;
        @(posedge clk);
        #1;
        check("R9 old config on write edge", res0, 32'h0000_00FF);
        @(negedge clk);
        cfg_we = 1'b0;
        m_gen = 16'h0; m_prop = 16'h0; m_out0 = tab(2); m_out1 = tab(10); m_cin = 1'b0;
        op_a = 32'h0000_0FF0; op_b = 32'h0000_00FF;
        @(posedge clk);
        #1;
        check("R9 new config next edge", res0, 32'h0000_0F0F);
    endtask

    task automatic t_random;
        for (int n = 0; n < 60; n++) begin
            logic [31:0] a, b, c, d, e0, e1;
            load($urandom()[15:0], $urandom()[15:0], $urandom(), $urandom(), $urandom()[0]);
            for (int k = 0; k < 4; k++) begin
                a = $urandom(); b = $urandom(); c = $urandom(); d = $urandom();
                if (k == 0) begin a = 32'hFFFF_FFFF; b = 32'hFFFF_FFFF; end
                ripple(a, b, c, d, e0, e1);
                exec(a, b, c, d);
                check("R10 ripple model res0", res0, e0);
                check("R10 ripple model res1", res1, e1);
            end
        end
    endtask

    initial begin
        t_reset();
        t_add();
        t_add_cin();
        t_sub();
        t_logic();
        t_index();
        t_ignore();
        t_timing();
        t_random();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule